// File: doc/BRIEF.md
# Fractal Tile Repack Address Generator

This block sits between a global-memory reader and an on-chip staging buffer for a matrix engine. A matrix arrives as a stream of elements in row-major order. The block passes each element through unchanged and attaches the address where that element belongs in a tiled ("fractal") layout. Each tile is an inner block of elements stored contiguously. Outer tiles are ordered along the reduction axis first. The inner tile width in elements is 32 bytes divided by the element byte width.

Software programs the row count, the column count, the element-width code and the operand kind, then pulses `start_i`. A left operand is an [M, K] matrix with 16-row inner tiles. A right operand is a [K, N] matrix with square inner tiles whose side is the tile width. The block checks the configuration, and if it is valid, walks the whole matrix one accepted beat at a time. It raises a one-cycle done pulse when the last element has left the output register. Addresses are built from row and column counters, shifts and one running tile-base accumulator, so no dimension multiplier is needed.

Top module: `nz_repack_addr`

## Requirements
- R1: For a left operand (`is_right_i`=0, rows=M, cols=K), element (m, k) at stream position m*K+k gets address ((k1*(M/16)+m1)*16+m0)*T+k0, with k1=k/T, k0=k%T, m1=m/16, m0=m%16, and T the tile width.
- R2: For a right operand (`is_right_i`=1, rows=K, cols=N), element (k, n) at stream position k*N+n gets address ((k1*(N/T)+n1)*T+k0)*T+n0, with k1=k/T, k0=k%T, n1=n/T, n0=n%T.
- R3: The tile width T comes from `ew_sel_i`: code 0 (1-byte elements) gives 32, code 1 (2-byte) gives 16, code 2 (4-byte) gives 8. Code 3 is illegal.
- R4: A start with code 3, a zero dimension, a left operand whose rows are not a multiple of 16 or whose columns are not a multiple of T, or a right operand with either dimension not a multiple of T sets `cfg_err_o` from the next cycle on. In that case `busy_o` and `in_ready_o` stay low. The next accepted start reloads `cfg_err_o`.
- R5: The position advances only on an accepted input beat (`in_valid_i` and `in_ready_o` both high). Idle input cycles do not disturb the address sequence.
- R6: While `out_valid_o` is high and `out_ready_i` is low, `out_addr_o` and `out_data_o` hold their values and `out_valid_o` stays high.
- R7: Once the last element has been accepted, `in_ready_o` stays low. `done_o` is high for exactly the one cycle after the edge at which the last output beat is taken, and `busy_o` is low in that same cycle.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running matrix keeps its configuration and `cfg_err_o` is unchanged.
- R9: After reset, `in_ready_o`, `out_valid_o`, `busy_o`, `done_o` and `cfg_err_o` are all low.
- R10: Output data equals input data, and elements leave in arrival order with one address per element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load configuration and begin a matrix |
| is_right_i | input | 1 | 0: left operand [M,K]; 1: right operand [K,N] |
| ew_sel_i | input | 2 | Element width code (0:1B, 1:2B, 2:4B) |
| rows_i | input | DIM_W | Row count of the row-major input |
| cols_i | input | DIM_W | Column count of the row-major input |
| in_valid_i | input | 1 | Input element valid |
| in_ready_o | output | 1 | Block accepts an input element |
| in_data_i | input | DATA_W | Input element |
| out_valid_o | output | 1 | Output element valid |
| out_ready_i | input | 1 | Downstream accepts the output element |
| out_data_o | output | DATA_W | Element passed through |
| out_addr_o | output | 2*DIM_W | Tiled destination address |
| busy_o | output | 1 | A matrix is in progress |
| done_o | output | 1 | One-cycle pulse after the last output beat |
| cfg_err_o | output | 1 | Last start had an illegal configuration |

## Verification
The bench targets the tile boundaries. Where the column tile wraps inside a row, a wrong accumulator would jump to the wrong outer tile. Where a row crosses a right-operand row tile, a wrong accumulator would repeat or skip a block of addresses. Random input gaps and output stalls check that an idle beat never moves the counters and that a stalled output is never overwritten; a design that got either wrong would drop or shift every later address. The bench also starts a matrix with illegal dimensions or width codes, which a loose check would accept and run, and pulses start in the middle of a run, which a design without a guard would use to reload its configuration.

// File: rtl/nz_pkg.sv
package nz_pkg;
  localparam int unsigned ROW_BYTES = 32;
  localparam int unsigned LG_ROW_BYTES = $clog2(ROW_BYTES);
  localparam int unsigned TILE_H = 16;

  typedef enum logic [1:0] {
    EW_8   = 2'd0,
    EW_16  = 2'd1,
    EW_32  = 2'd2,
    EW_BAD = 2'd3
  } ew_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } st_e;

  // log2 of the tile width in elements
  function automatic logic [2:0] tile_lg(input logic [1:0] code);
    return 3'(LG_ROW_BYTES - int'(code));
  endfunction
endpackage

// File: rtl/nz_cfg_check.sv
module nz_cfg_check
  import nz_pkg::*;
#(
  parameter int unsigned DIM_W  = 10,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              is_right_i,
  input  logic [1:0]        ew_sel_i,
  input  logic [DIM_W-1:0]  rows_i,
  input  logic [DIM_W-1:0]  cols_i,
  output logic              ok_o,
  output logic              is_right_o,
  output logic [2:0]        lg_o,
  output logic [DIM_W-1:0]  mask_o,
  output logic [DIM_W-1:0]  rows_o,
  output logic [DIM_W-1:0]  cols_o,
  output logic [ADDR_W-1:0] stride_o
);
  localparam logic [DIM_W-1:0] H_MASK = DIM_W'(TILE_H - 1);

  logic [2:0]        lg_d;
  logic [DIM_W-1:0]  mask_d;
  logic [ADDR_W-1:0] stride_d;
  logic              rows_fit, cols_fit;

  always_comb begin
    lg_d     = tile_lg(ew_sel_i);
    mask_d   = (DIM_W'(1) << lg_d) - DIM_W'(1);
    cols_fit = (cols_i & mask_d) == '0;
    rows_fit = is_right_i ? ((rows_i & mask_d) == '0) : ((rows_i & H_MASK) == '0);
    ok_o     = (ew_sel_i != EW_BAD) && (rows_i != '0) && (cols_i != '0) && rows_fit && cols_fit;
    // outer reduction-tile stride: left steps per column tile, right per row tile
    stride_d = (is_right_i ? ADDR_W'(cols_i) : ADDR_W'(rows_i)) << lg_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_right_o <= 1'b0;
      lg_o       <= 3'd3;
      mask_o     <= DIM_W'(7);
      rows_o     <= '0;
      cols_o     <= '0;
      stride_o   <= '0;
    end else if (load_i) begin
      is_right_o <= is_right_i;
      lg_o       <= lg_d;
      mask_o     <= mask_d;
      rows_o     <= rows_i;
      cols_o     <= cols_i;
      stride_o   <= stride_d;
    end
  end

  a_r3_tile_width_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (lg_o >= 3'd3) && (lg_o <= 3'(LG_ROW_BYTES)));
endmodule

// File: rtl/nz_walker.sv
module nz_walker #(
  parameter int unsigned DIM_W  = 10,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              adv_i,
  input  logic              is_right_i,
  input  logic [2:0]        lg_i,
  input  logic [DIM_W-1:0]  mask_i,
  input  logic [DIM_W-1:0]  rows_i,
  input  logic [DIM_W-1:0]  cols_i,
  input  logic [ADDR_W-1:0] stride_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [DIM_W-1:0]  r_q, c_q;
  logic [ADDR_W-1:0] acc_q;
  logic [DIM_W-1:0]  r0, c0;
  logic              row_end;
  logic [ADDR_W-1:0] left_addr, right_addr;

  always_comb begin
    r0      = r_q & mask_i;
    c0      = c_q & mask_i;
    row_end = c_q == cols_i - DIM_W'(1);
    last_o  = row_end && (r_q == rows_i - DIM_W'(1));
    // left: k1 stride in acc, full row index scaled by tile width
    left_addr  = acc_q + (ADDR_W'(r_q) << lg_i) + ADDR_W'(c0);
    // right: k1 stride in acc, k0 row scaled by T, n1 scaled by T*T
    right_addr = acc_q + (ADDR_W'(r0) << lg_i) + (ADDR_W'(c_q & ~mask_i) << lg_i) + ADDR_W'(c0);
    addr_o     = is_right_i ? right_addr : left_addr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q   <= '0;
      c_q   <= '0;
      acc_q <= '0;
    end else if (init_i) begin
      r_q   <= '0;
      c_q   <= '0;
      acc_q <= '0;
    end else if (adv_i) begin
      if (row_end) begin
        c_q <= '0;
        r_q <= r_q + DIM_W'(1);
        if (!is_right_i)         acc_q <= '0;
        else if (r0 == mask_i)   acc_q <= acc_q + stride_i;
      end else begin
        c_q <= c_q + DIM_W'(1);
        if (!is_right_i && (c0 == mask_i)) acc_q <= acc_q + stride_i;
      end
    end
  end

  a_r5_hold_position: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !init_i) |=> ($stable(r_q) && $stable(c_q) && $stable(acc_q)));
  a_r10_row_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !init_i && row_end) |=> (c_q == '0));
endmodule

// File: rtl/nz_out_stage.sv
module nz_out_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      addr_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      addr_o  <= addr_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  a_r6_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));
endmodule

// File: rtl/nz_repack_addr.sv
module nz_repack_addr
  import nz_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIM_W  = 10,
  localparam int unsigned ADDR_W = 2 * DIM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_right_i,
  input  logic [1:0]        ew_sel_i,
  input  logic [DIM_W-1:0]  rows_i,
  input  logic [DIM_W-1:0]  cols_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  st_e               st_q;
  logic              start_fire, cfg_ok, load_cfg, in_fire, out_fire, last;
  logic              c_right;
  logic [2:0]        c_lg;
  logic [DIM_W-1:0]  c_mask, c_rows, c_cols;
  logic [ADDR_W-1:0] c_stride, walk_addr;

  assign start_fire = start_i && (st_q == ST_IDLE);
  assign load_cfg   = start_fire && cfg_ok;
  assign in_ready_o = (st_q == ST_RUN) && (!out_valid_o || out_ready_i);
  assign in_fire    = in_valid_i && in_ready_o;
  assign out_fire   = out_valid_o && out_ready_i;
  assign busy_o     = st_q != ST_IDLE;

  nz_cfg_check #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni,
    .load_i(load_cfg), .is_right_i, .ew_sel_i, .rows_i, .cols_i,
    .ok_o(cfg_ok), .is_right_o(c_right), .lg_o(c_lg), .mask_o(c_mask),
    .rows_o(c_rows), .cols_o(c_cols), .stride_o(c_stride)
  );

  nz_walker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_walk (
    .clk_i, .rst_ni,
    .init_i(load_cfg), .adv_i(in_fire), .is_right_i(c_right), .lg_i(c_lg),
    .mask_i(c_mask), .rows_i(c_rows), .cols_i(c_cols), .stride_i(c_stride),
    .addr_o(walk_addr), .last_o(last)
  );

  nz_out_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_out (
    .clk_i, .rst_ni,
    .load_i(in_fire), .data_i(in_data_i), .addr_i(walk_addr), .ready_i(out_ready_i),
    .valid_o(out_valid_o), .data_o(out_data_o), .addr_o(out_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      done_o    <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_fire) cfg_err_o <= !cfg_ok;
      unique case (st_q)
        ST_IDLE:  if (load_cfg) st_q <= ST_RUN;
        ST_RUN:   if (in_fire && last) st_q <= ST_DRAIN;
        ST_DRAIN: if (out_fire) begin
          st_q   <= ST_IDLE;
          done_o <= 1'b1;
        end
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r7_drain_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRAIN) |-> !in_ready_o);
  a_r4_err_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!busy_o && !in_ready_o));
  a_r8_busy_cfg_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(cfg_err_o));
endmodule

// File: tb/sim_nz_repack_addr.sv
module sim_nz_repack_addr;
  localparam int DATA_W = 32;
  localparam int DIM_W  = 10;
  localparam int ADDR_W = 2 * DIM_W;
  localparam int NCASE  = 6;
  // {is_right, ew_code, rows, cols, random_stalls}
  localparam logic [23:0] CASES [NCASE] = '{
    {1'b0, 2'd1, 10'd32, 10'd32, 1'b1},
    {1'b1, 2'd2, 10'd16, 10'd24, 1'b1},
    {1'b0, 2'd0, 10'd16, 10'd64, 1'b0},
    {1'b1, 2'd1, 10'd16, 10'd16, 1'b1},
    {1'b0, 2'd2, 10'd48, 10'd8,  1'b1},
    {1'b1, 2'd0, 10'd32, 10'd32, 1'b0}
  };

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic              start_i = 1'b0, is_right_i = 1'b0;
  logic [1:0]        ew_sel_i = 2'd0;
  logic [DIM_W-1:0]  rows_i = '0, cols_i = '0;
  logic              in_valid_i = 1'b0, out_ready_i = 1'b0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              in_ready_o, out_valid_o, busy_o, done_o, cfg_err_o;
  logic [DATA_W-1:0] out_data_o;
  logic [ADDR_W-1:0] out_addr_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk_i = ~clk_i;

  nz_repack_addr #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tile_w(input int code);
    return 32 >> code;
  endfunction

  function automatic int exp_addr(input bit right, input int t, input int rows, input int cols, input int idx);
    int r = idx / cols;
    int c = idx % cols;
    if (!right) return (((c / t) * (rows / 16) + (r / 16)) * 16 + (r % 16)) * t + (c % t);
    return (((r / t) * (cols / t) + (c / t)) * t + (r % t)) * t + (c % t);
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_start(input bit right, input int ew, input int rows, input int cols);
    @(negedge clk_i);
    is_right_i = right; ew_sel_i = 2'(ew); rows_i = DIM_W'(rows); cols_i = DIM_W'(cols);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run_case(input int id, input bit right, input int ew, input int rows, input int cols,
                          input bit stall, input bit mid_start);
    int n = rows * cols;
    int t = tile_w(ew);
    int nin = 0, nout = 0;
    bit held = 0;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_data;
    string rq = right ? "R2" : "R1";
    do_start(right, ew, rows, cols);
    chk(busy_o && !cfg_err_o, "R3 start accepted", busy_o, 1);
    while (nout < n) begin
      if (held) chk(out_valid_o && out_addr_o == p_addr && out_data_o == p_data,
                    "R6 stalled output changed", out_addr_o, p_addr);
      if (nin == n && nout < n) chk(!in_ready_o, "R7 ready after last input", in_ready_o, 0);
      step_lfsr();
      in_valid_i  = (nin < n) && (!stall || lfsr[0] || lfsr[1]);
      in_data_i   = (id << 16) | nin;
      out_ready_i = !stall || lfsr[2] || lfsr[3];
      start_i     = mid_start && (nin == n / 2);
      if (start_i) begin is_right_i = ~right; ew_sel_i = 2'd3; end
      #1;
      held  = out_valid_o && !out_ready_i;
      p_addr = out_addr_o; p_data = out_data_o;
      if (out_valid_o && out_ready_i) begin
        int ea = exp_addr(right, t, rows, cols, nout);
        chk(int'(out_addr_o) == ea, stall ? {rq, "/R5 address"} : {rq, "/R3 address"}, out_addr_o, ea);
        chk(out_data_o == DATA_W'((id << 16) | nout), "R10 data order", out_data_o, (id << 16) | nout);
        nout++;
      end
      if (in_valid_i && in_ready_o) nin++;
      @(negedge clk_i);
      start_i = 1'b0;
      is_right_i = right; ew_sel_i = 2'(ew);
    end
    in_valid_i = 1'b0; out_ready_i = 1'b0;
    chk(done_o && !busy_o && !in_ready_o, "R7 done pulse", done_o, 1);
    if (mid_start) chk(!cfg_err_o, "R8 start ignored while busy", cfg_err_o, 0);
    @(negedge clk_i);
    chk(!done_o, "R7 done one cycle", done_o, 0);
  endtask

  task automatic bad_cfg(input bit right, input int ew, input int rows, input int cols);
    do_start(right, ew, rows, cols);
    chk(cfg_err_o && !busy_o && !in_ready_o, "R4 illegal config", cfg_err_o, 1);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    chk(!in_ready_o && !out_valid_o, "R4 no input taken", out_valid_o, 0);
    in_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!in_ready_o && !out_valid_o && !busy_o && !done_o && !cfg_err_o, "R9 reset state",
        {in_ready_o, out_valid_o, busy_o, done_o, cfg_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!in_ready_o && !busy_o, "R9 idle after reset", busy_o, 0);

    for (int i = 0; i < NCASE; i++) begin
      logic [23:0] v = CASES[i];
      run_case(i, v[23], int'(v[22:21]), int'(v[20:11]), int'(v[10:1]), v[0], 1'b0);
    end

    bad_cfg(1'b0, 1, 24, 32);
    bad_cfg(1'b0, 1, 32, 24);
    bad_cfg(1'b1, 2, 12, 16);
    bad_cfg(1'b1, 0, 32, 48);
    bad_cfg(1'b0, 3, 16, 16);
    bad_cfg(1'b0, 1, 0, 16);

    run_case(7, 1'b0, 1, 16, 16, 1'b1, 1'b1);
    run_case(8, 1'b1, 2, 8, 8, 1'b0, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule